// File: doc/BRIEF.md
# Text and Semigraphics Video Generator

This block turns a character-cell screen image held in an external video RAM into a serial pixel stream with horizontal and vertical sync. It runs its own dot, line and cell counters, issues one video-RAM read per displayed cell, and decides per cell between two ways of drawing it. A byte with its top bit clear is a text cell: its low bits form a glyph code that, together with the scan line inside the cell, addresses an external character ROM with a synchronous read port. A byte with its top bit set is a block-graphics cell: its six low bits light a 2 by 3 grid of blocks, and the pattern is computed inside the block without touching the ROM.

Three static inputs shape the picture. The lowercase enable decides whether bit 6 of a text byte reaches the ROM; with it off only the first 64 glyphs can be reached. The low-resolution select shows only the even-addressed cells and shifts each pixel out for two clocks, so every cell is twice as wide while the line count stays the same. The field-rate select chooses one of two vertical totals for a 50 Hz or 60 Hz field. The reads are pipelined, and the sync outputs are delayed by the same amount, so every cell lands exactly on its column boundary.

One clock is one dot. Line and frame lengths, cell size and screen size are parameters; by default the screen is 64 by 16 cells of 6 by 12 dots.

Top module: `char_video_gen`

## Requirements
- R1: With byte bit 7 clear the cell is text: the ROM address is {code[6:0], line[3:0]} with the glyph code in the upper bits and the scan line within the cell in the low bits, and the ROM word is shown with its most significant bit as the leftmost dot.
- R2: With byte bit 7 set the cell is block graphics on a grid two blocks wide and three tall; bits 0 to 5 light top-left, top-right, middle-left, middle-right, bottom-left and bottom-right, each block being CELL_W/2 dots wide and CELL_H/3 lines tall, and a lit block shows as 1.
- R3: With lower_en low, bit 6 of a text byte is ignored: code[6] is 0 and code[5:0] is byte[5:0].
- R4: With lower_en high, code[6] equals byte bit 6, so the second 64-glyph page is displayed.
- R5: With lores high, the cell in column c of row r is read from address r*COLS + 2c; odd addresses never affect the output.
- R6: With lores high, each dot of a glyph or graphics pattern is held for two clocks, so a cell is 2*CELL_W clocks wide and COLS/2 cells fill the line.
- R7: The row layout, active line range and vertical sync are the same with lores high as with lores low.
- R8: A line is H_TOTAL clocks; a frame is V_TOTAL_50 lines when field50 is high and V_TOTAL_60 lines when it is low.
- R9: pix is 0 whenever the dot column is at or beyond COLS*CELL_W or the line is at or beyond ROWS*CELL_H.
- R10: hsync is high for dot columns HS_START to HS_START+HS_LEN-1 and vsync for lines VS_START to VS_START+VS_LEN-1, both active high.
- R11: While rst is high, pix, hsync, vsync, vram_addr and rom_addr are all 0.
- R12: The counters are at column 0, line 0 on the first clock edge with rst low, and pix, hsync and vsync show the state of counter position n exactly four clocks after that position is held, so the first dot of every cell appears on its column boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| lores | input | 1 | Double-width mode, even cells only |
| lower_en | input | 1 | Pass byte bit 6 into the glyph code |
| field50 | input | 1 | High selects the 50 Hz vertical total |
| vram_addr | output | $clog2(COLS*ROWS) | Video RAM read address |
| vram_data | input | 8 | Video RAM read data, one clock after the address |
| rom_addr | output | 7+$clog2(CELL_H) | Character ROM address {code, line} |
| rom_data | input | CELL_W | Character ROM row, one clock after the address |
| pix | output | 1 | Serial pixel |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |

## Verification
The screen is filled with a mix of text bytes with and without bit 6 and graphics bytes lighting different block sets, and every output sample of a full frame is compared against a model built from the requirements, so a wrong glyph page, a swapped block order or a misplaced band shows up as a wrong dot. The same image is shown in both resolutions and with lowercase on and off; a text byte with bit 6 set separates the two lowercase settings, and a second low-resolution frame with every odd cell inverted must give an identical picture. Dots on cell boundaries are scored separately so that a pipeline that is one clock early or late is told apart from a decoding error, and the vsync period is measured with each field-rate setting.

// File: rtl/cvg_pkg.sv
package cvg_pkg;

  localparam int CODE_W = 7;
  localparam int BYTE_W = 8;
  localparam int PIPE_DEPTH = 4;

  // Per-dot control flags travelling alongside the fetch pipeline
  typedef struct packed {
    logic ld;   // first dot of a displayed cell
    logic adv;  // shift register advances on this dot
    logic act;  // inside the active picture
    logic hs;   // horizontal sync window
    logic vs;   // vertical sync window
  } cvg_ctl_t;

endpackage

// File: rtl/cvg_timing.sv
module cvg_timing
  import cvg_pkg::*;
#(
  parameter int COLS       = 64,
  parameter int ROWS       = 16,
  parameter int CELL_W     = 6,
  parameter int CELL_H     = 12,
  parameter int H_TOTAL    = 448,
  parameter int HS_START   = 400,
  parameter int HS_LEN     = 32,
  parameter int V_TOTAL_50 = 312,
  parameter int V_TOTAL_60 = 262,
  parameter int VS_START   = 220,
  parameter int VS_LEN     = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            lores,
  input  logic                            field50,
  output logic [$clog2(COLS*ROWS)-1:0]    vram_addr,
  output logic [$clog2(CELL_H)-1:0]       line_s2,
  output cvg_ctl_t                        ctl_s4
);

  localparam int ACT_W  = COLS * CELL_W;
  localparam int ACT_H  = ROWS * CELL_H;
  localparam int VT_MAX = (V_TOTAL_50 > V_TOTAL_60) ? V_TOTAL_50 : V_TOTAL_60;
  localparam int HW     = $clog2(H_TOTAL);
  localparam int VW     = $clog2(VT_MAX);
  localparam int DW     = $clog2(2 * CELL_W);
  localparam int CLW    = $clog2(COLS);
  localparam int RW     = $clog2(ROWS);
  localparam int LW     = $clog2(CELL_H);
  localparam int VA_W   = $clog2(COLS * ROWS);

  localparam logic [HW-1:0] H_LAST  = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] H_ACT   = HW'(ACT_W);
  localparam logic [HW-1:0] HS_ON   = HW'(HS_START);
  localparam logic [HW-1:0] HS_OFF  = HW'(HS_START + HS_LEN);
  localparam logic [VW-1:0] V_ACT   = VW'(ACT_H);
  localparam logic [VW-1:0] VS_ON   = VW'(VS_START);
  localparam logic [VW-1:0] VS_OFF  = VW'(VS_START + VS_LEN);
  localparam logic [VW-1:0] V_END50 = VW'(V_TOTAL_50 - 1);
  localparam logic [VW-1:0] V_END60 = VW'(V_TOTAL_60 - 1);
  localparam logic [DW-1:0] D_END_HI = DW'(CELL_W - 1);
  localparam logic [DW-1:0] D_END_LO = DW'(2 * CELL_W - 1);
  localparam logic [LW-1:0] L_END   = LW'(CELL_H - 1);
  localparam logic [VA_W-1:0] COLS_C = VA_W'(COLS);

  logic [HW-1:0]  hcnt;
  logic [VW-1:0]  vcnt;
  logic [DW-1:0]  dcnt;
  logic [CLW-1:0] ccnt;
  logic [LW-1:0]  lcnt;
  logic [RW-1:0]  rcnt;

  logic [DW-1:0]  d_end;
  logic [VW-1:0]  v_end;
  assign d_end = lores ? D_END_LO : D_END_HI;
  assign v_end = field50 ? V_END50 : V_END60;

  // Dot, cell, line and row counters, all advanced incrementally
  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= '0;
      dcnt <= '0;
      ccnt <= '0;
      lcnt <= '0;
      rcnt <= '0;
    end else if (hcnt == H_LAST) begin
      hcnt <= '0;
      dcnt <= '0;
      ccnt <= '0;
      if (vcnt == v_end) begin
        vcnt <= '0;
        lcnt <= '0;
        rcnt <= '0;
      end else begin
        vcnt <= vcnt + 1'b1;
        if (lcnt == L_END) begin
          lcnt <= '0;
          rcnt <= rcnt + 1'b1;
        end else begin
          lcnt <= lcnt + 1'b1;
        end
      end
    end else begin
      hcnt <= hcnt + 1'b1;
      if (dcnt == d_end) begin
        dcnt <= '0;
        ccnt <= ccnt + 1'b1;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end

  cvg_ctl_t ctl_c;
  always_comb begin
    ctl_c.act = (hcnt < H_ACT) && (vcnt < V_ACT);
    ctl_c.ld  = ctl_c.act && (dcnt == '0);
    ctl_c.adv = !lores || !dcnt[0];
    ctl_c.hs  = (hcnt >= HS_ON) && (hcnt < HS_OFF);
    ctl_c.vs  = (vcnt >= VS_ON) && (vcnt < VS_OFF);
  end

  logic [VA_W-1:0] col_off;
  assign col_off = lores ? VA_W'({ccnt, 1'b0}) : VA_W'(ccnt);

  cvg_ctl_t       ctl_p  [PIPE_DEPTH];
  logic [LW-1:0]  line_p [2];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PIPE_DEPTH; i++) ctl_p[i] <= '0;
      line_p[0] <= '0;
      line_p[1] <= '0;
      vram_addr <= '0;
    end else begin
      ctl_p[0] <= ctl_c;
      for (int i = 1; i < PIPE_DEPTH; i++) ctl_p[i] <= ctl_p[i-1];
      line_p[0] <= lcnt;
      line_p[1] <= line_p[0];
      if (ctl_c.ld) vram_addr <= VA_W'(rcnt) * COLS_C + col_off;
    end
  end

  assign line_s2 = line_p[1];
  assign ctl_s4  = ctl_p[PIPE_DEPTH-1];

endmodule

// File: rtl/cvg_cell_decode.sv
module cvg_cell_decode
  import cvg_pkg::*;
#(
  parameter int CELL_W = 6,
  parameter int CELL_H = 12
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               lower_en,
  input  logic [BYTE_W-1:0]                  vram_data,
  input  logic [$clog2(CELL_H)-1:0]          line,
  output logic [CODE_W+$clog2(CELL_H)-1:0]   rom_addr,
  output logic [CELL_W-1:0]                  gfx_pat,
  output logic                               is_gfx
);

  localparam int LW   = $clog2(CELL_H);
  localparam int BLK_H = CELL_H / 3;
  localparam int HALF  = CELL_W / 2;
  localparam logic [LW-1:0] BAND1 = LW'(BLK_H);
  localparam logic [LW-1:0] BAND2 = LW'(2 * BLK_H);

  logic left_on, right_on;
  always_comb begin
    if (line < BAND1) begin
      left_on  = vram_data[0];
      right_on = vram_data[1];
    end else if (line < BAND2) begin
      left_on  = vram_data[2];
      right_on = vram_data[3];
    end else begin
      left_on  = vram_data[4];
      right_on = vram_data[5];
    end
  end

  logic [CELL_W-1:0] pat_c;
  for (genvar i = 0; i < CELL_W; i++) begin : g_dot
    if (i < HALF) begin : g_left
      assign pat_c[CELL_W-1-i] = left_on;
    end else begin : g_right
      assign pat_c[CELL_W-1-i] = right_on;
    end
  end

  logic [CODE_W-1:0] code;
  assign code = {lower_en & vram_data[6], vram_data[5:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr <= '0;
      gfx_pat  <= '0;
      is_gfx   <= 1'b0;
    end else begin
      rom_addr <= {code, line};
      gfx_pat  <= pat_c;
      is_gfx   <= vram_data[7];
    end
  end

endmodule

// File: rtl/cvg_shifter.sv
module cvg_shifter
  import cvg_pkg::*;
#(
  parameter int CELL_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  cvg_ctl_t          ctl,
  input  logic [CELL_W-1:0] rom_data,
  input  logic [CELL_W-1:0] gfx_pat,
  input  logic              is_gfx,
  output logic              pix,
  output logic              hsync,
  output logic              vsync
);

  logic [CELL_W-1:0] gfx_q;
  logic              isg_q;
  logic [CELL_W-1:0] sr;
  logic              cur;

  logic [CELL_W-1:0] pat;
  logic [CELL_W-1:0] sr_n;
  logic              cur_n;

  always_comb begin
    pat = isg_q ? gfx_q : rom_data;
    if (ctl.ld) begin
      cur_n = pat[CELL_W-1];
      sr_n  = {pat[CELL_W-2:0], 1'b0};
    end else if (ctl.adv) begin
      cur_n = sr[CELL_W-1];
      sr_n  = {sr[CELL_W-2:0], 1'b0};
    end else begin
      cur_n = cur;
      sr_n  = sr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gfx_q <= '0;
      isg_q <= 1'b0;
      sr    <= '0;
      cur   <= 1'b0;
      pix   <= 1'b0;
      hsync <= 1'b0;
      vsync <= 1'b0;
    end else begin
      gfx_q <= gfx_pat;
      isg_q <= is_gfx;
      sr    <= sr_n;
      cur   <= cur_n;
      pix   <= cur_n & ctl.act;
      hsync <= ctl.hs;
      vsync <= ctl.vs;
    end
  end

endmodule

// File: rtl/char_video_gen.sv
module char_video_gen
  import cvg_pkg::*;
#(
  parameter int COLS       = 64,
  parameter int ROWS       = 16,
  parameter int CELL_W     = 6,
  parameter int CELL_H     = 12,
  parameter int H_TOTAL    = 448,
  parameter int HS_START   = 400,
  parameter int HS_LEN     = 32,
  parameter int V_TOTAL_50 = 312,
  parameter int V_TOTAL_60 = 262,
  parameter int VS_START   = 220,
  parameter int VS_LEN     = 4
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 lores,
  input  logic                                 lower_en,
  input  logic                                 field50,
  output logic [$clog2(COLS*ROWS)-1:0]         vram_addr,
  input  logic [7:0]                           vram_data,
  output logic [6+$clog2(CELL_H):0]            rom_addr,
  input  logic [CELL_W-1:0]                    rom_data,
  output logic                                 pix,
  output logic                                 hsync,
  output logic                                 vsync
);

  localparam int LW = $clog2(CELL_H);

  cvg_ctl_t           ctl_s4;
  logic [LW-1:0]      line_s2;
  logic [CELL_W-1:0]  gfx_pat;
  logic               is_gfx;

  cvg_timing #(
    .COLS(COLS), .ROWS(ROWS), .CELL_W(CELL_W), .CELL_H(CELL_H),
    .H_TOTAL(H_TOTAL), .HS_START(HS_START), .HS_LEN(HS_LEN),
    .V_TOTAL_50(V_TOTAL_50), .V_TOTAL_60(V_TOTAL_60),
    .VS_START(VS_START), .VS_LEN(VS_LEN)
  ) u_timing (
    .clk(clk), .rst(rst), .lores(lores), .field50(field50),
    .vram_addr(vram_addr), .line_s2(line_s2), .ctl_s4(ctl_s4)
  );

  cvg_cell_decode #(.CELL_W(CELL_W), .CELL_H(CELL_H)) u_decode (
    .clk(clk), .rst(rst), .lower_en(lower_en),
    .vram_data(vram_data), .line(line_s2),
    .rom_addr(rom_addr), .gfx_pat(gfx_pat), .is_gfx(is_gfx)
  );

  cvg_shifter #(.CELL_W(CELL_W)) u_shift (
    .clk(clk), .rst(rst), .ctl(ctl_s4),
    .rom_data(rom_data), .gfx_pat(gfx_pat), .is_gfx(is_gfx),
    .pix(pix), .hsync(hsync), .vsync(vsync)
  );

endmodule

// File: rtl/cvg_checker.sv
module cvg_checker #(
  parameter int H_TOTAL    = 448,
  parameter int V_TOTAL_50 = 312,
  parameter int V_TOTAL_60 = 262,
  parameter int VA_W       = 10,
  parameter int ROM_AW     = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              lores,
  input logic              lower_en,
  input logic              field50,
  input logic [VA_W-1:0]   vram_addr,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              pix,
  input logic              hsync,
  input logic              vsync
);

  logic        hs_q, vs_q, h_seen, v_seen, f_q;
  int unsigned h_cyc, v_cyc;
  int unsigned v_exp;

  assign v_exp = (field50 ? V_TOTAL_50 : V_TOTAL_60) * H_TOTAL;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q <= 1'b0; vs_q <= 1'b0; h_seen <= 1'b0; v_seen <= 1'b0;
      f_q <= 1'b0; h_cyc <= 0; v_cyc <= 0;
    end else begin
      hs_q <= hsync;
      vs_q <= vsync;
      if (hsync && !hs_q) begin
        h_cyc <= 1; h_seen <= 1'b1;
      end else begin
        h_cyc <= h_cyc + 1;
      end
      if (vsync && !vs_q) begin
        v_cyc <= 1; v_seen <= 1'b1; f_q <= field50;
      end else begin
        v_cyc <= v_cyc + 1;
      end
    end
  end

  // R3: no second-page glyph address while lowercase is off
  assert_no_page2_R3: assert property (@(posedge clk) disable iff (rst)
    (!lower_en && $past(!lower_en)) |-> !rom_addr[ROM_AW-1]);

  // R5: every new fetch in low-resolution mode is at an even address
  assert_even_fetch_R5: assert property (@(posedge clk) disable iff (rst)
    (lores && $past(lores) && (vram_addr != $past(vram_addr))) |-> !vram_addr[0]);

  // R8: line period
  assert_line_len_R8: assert property (@(posedge clk) disable iff (rst)
    (hsync && !hs_q && h_seen) |-> (h_cyc == H_TOTAL));

  // R8: field period follows the rate select
  assert_field_len_R8: assert property (@(posedge clk) disable iff (rst)
    (vsync && !vs_q && v_seen && (f_q == field50)) |-> (v_cyc == v_exp));

  // R9: no lit pixel while either sync is active
  assert_blank_in_sync_R9: assert property (@(posedge clk) disable iff (rst)
    pix |-> (!hsync && !vsync));

endmodule

bind char_video_gen cvg_checker #(
  .H_TOTAL(H_TOTAL), .V_TOTAL_50(V_TOTAL_50), .V_TOTAL_60(V_TOTAL_60),
  .VA_W($clog2(COLS*ROWS)), .ROM_AW(7+$clog2(CELL_H))
) u_chk (
  .clk(clk), .rst(rst), .lores(lores), .lower_en(lower_en), .field50(field50),
  .vram_addr(vram_addr), .rom_addr(rom_addr), .pix(pix),
  .hsync(hsync), .vsync(vsync)
);

// File: tb/char_video_gen_tb.sv
`timescale 1ns/1ps
module char_video_gen_tb;

  localparam int C    = 4;
  localparam int R    = 2;
  localparam int CW   = 6;
  localparam int CH   = 12;
  localparam int HT   = 32;
  localparam int HSS  = 26;
  localparam int HSL  = 3;
  localparam int V50  = 31;
  localparam int V60  = 28;
  localparam int VSS  = 25;
  localparam int VSL  = 2;
  localparam int NCELL = C * R;
  localparam int LAT  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lores = 1'b0, lower_en = 1'b0, field50 = 1'b0;
  logic [$clog2(NCELL)-1:0] vram_addr;
  logic [7:0]  vram_data;
  logic [10:0] rom_addr;
  logic [CW-1:0] rom_data;
  logic pix, hsync, vsync;

  logic [7:0] vmem [NCELL];

  int nchecks = 0;
  int nerrs   = 0;

  always #4 clk = ~clk;

  function automatic logic [5:0] glyph(input logic [10:0] a);
    logic [7:0] t;
    t = 8'(a[10:4] * 13) + 8'(a[3:0] * 7) + 8'd3;
    return t[5:0] ^ {t[7:6], t[7:6], t[7:6]};
  endfunction

  always_ff @(posedge clk) begin
    vram_data <= vmem[vram_addr];
    rom_data  <= glyph(rom_addr);
  end

  char_video_gen #(
    .COLS(C), .ROWS(R), .CELL_W(CW), .CELL_H(CH), .H_TOTAL(HT),
    .HS_START(HSS), .HS_LEN(HSL), .V_TOTAL_50(V50), .V_TOTAL_60(V60),
    .VS_START(VSS), .VS_LEN(VSL)
  ) u_dut (
    .clk(clk), .rst(rst), .lores(lores), .lower_en(lower_en), .field50(field50),
    .vram_addr(vram_addr), .vram_data(vram_data), .rom_addr(rom_addr),
    .rom_data(rom_data), .pix(pix), .hsync(hsync), .vsync(vsync)
  );

  task automatic check(input bit ok, input string tag, input string what);
    nchecks++;
    if (!ok) begin
      nerrs++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchecks++;
    nerrs++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic load_mem(input bit flip_odd);
    logic [7:0] img [NCELL];
    img = '{8'h05, 8'h4A, 8'hA9, 8'h7E, 8'h5C, 8'h3C, 8'hC6, 8'h61};
    for (int i = 0; i < NCELL; i++)
      vmem[i] = (flip_odd && i[0]) ? ~img[i] : img[i];
  endtask

  // Hold reset, set static inputs, release on a falling edge
  task automatic do_reset(input bit lr, input bit lc, input bit f50);
    rst = 1'b1;
    lores = lr; lower_en = lc; field50 = f50;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pix == 1'b0, "R11", $sformatf("pix actual %0b expected 0", pix));
    check(hsync == 1'b0, "R11", $sformatf("hsync actual %0b expected 0", hsync));
    check(vsync == 1'b0, "R11", $sformatf("vsync actual %0b expected 0", vsync));
    check(vram_addr == '0, "R11", $sformatf("vram_addr actual %0d expected 0", vram_addr));
    check(rom_addr == '0, "R11", $sformatf("rom_addr actual %0d expected 0", rom_addr));
  endtask

  // Compare one whole frame sample by sample; score six classes
  task automatic run_frame(input bit lr, input bit lc, input string name);
    string tags [6];
    int    ecnt [6];
    string first [6];
    int    frame;
    tags[0] = lr ? "R6" : "R1";
    tags[1] = lc ? "R4" : "R3";
    tags[2] = lr ? "R5" : "R2";
    tags[3] = "R9";
    tags[4] = lr ? "R7" : "R10";
    tags[5] = "R12";
    for (int c = 0; c < 6; c++) begin ecnt[c] = 0; first[c] = ""; end
    frame = HT * V60;
    do_reset(lr, lc, 1'b0);
    for (int j = 0; j < frame + LAT; j++) begin
      @(posedge clk);
      @(negedge clk);
      if (j >= LAT) begin
        int n, h, v, row, line, col, dot, addr, band, cls;
        bit act, first_dot, pe, hse, vse;
        logic [7:0] b;
        logic [6:0] code;
        logic [5:0] g;
        n = j - LAT;
        h = n % HT;
        v = (n / HT) % V60;
        act = (h < C * CW) && (v < R * CH);
        hse = (h >= HSS) && (h < HSS + HSL);
        vse = (v >= VSS) && (v < VSS + VSL);
        pe = 1'b0;
        cls = 3;
        if (act) begin
          row = v / CH;
          line = v % CH;
          if (lr) begin
            col = h / (2 * CW);
            dot = (h % (2 * CW)) / 2;
            addr = row * C + 2 * col;
            first_dot = (h % (2 * CW)) == 0;
          end else begin
            col = h / CW;
            dot = h % CW;
            addr = row * C + col;
            first_dot = dot == 0;
          end
          b = vmem[addr];
          if (b[7]) begin
            band = line / (CH / 3);
            pe = (dot < CW / 2) ? b[2 * band] : b[2 * band + 1];
            cls = 2;
          end else begin
            code = {lc & b[6], b[5:0]};
            g = glyph({code, 4'(line)});
            pe = g[CW - 1 - dot];
            cls = b[6] ? 1 : 0;
          end
          if (first_dot) cls = 5;
        end
        if (pix !== pe) begin
          if (ecnt[cls] == 0)
            first[cls] = $sformatf("%s pix at h=%0d v=%0d actual %0b expected %0b",
                                   name, h, v, pix, pe);
          ecnt[cls]++;
        end
        if (hsync !== hse || vsync !== vse) begin
          if (ecnt[4] == 0)
            first[4] = $sformatf("%s sync at h=%0d v=%0d actual %0b%0b expected %0b%0b",
                                 name, h, v, hsync, vsync, hse, vse);
          ecnt[4]++;
        end
      end
    end
    for (int c = 0; c < 6; c++)
      check(ecnt[c] == 0, tags[c], $sformatf("%0d mismatches, first: %s", ecnt[c], first[c]));
  endtask

  // Measure the vsync period at the ports
  task automatic test_field(input bit f50);
    int  cyc, expv;
    bit  prev, seen, done;
    expv = HT * (f50 ? V50 : V60);
    do_reset(1'b0, 1'b0, f50);
    prev = 1'b0; seen = 1'b0; done = 1'b0; cyc = 0;
    for (int k = 0; k < 3 * HT * V50 && !done; k++) begin
      @(negedge clk);
      if (seen) cyc++;
      if (vsync && !prev) begin
        if (seen) done = 1'b1;
        else begin seen = 1'b1; cyc = 0; end
      end
      prev = vsync;
    end
    check(done && cyc == expv, "R8",
          $sformatf("field50=%0b period actual %0d expected %0d", f50, cyc, expv));
  endtask

  initial begin
    load_mem(1'b0);
    test_reset();
    run_frame(1'b0, 1'b0, "hires lower off");
    run_frame(1'b0, 1'b1, "hires lower on");
    run_frame(1'b1, 1'b0, "lores lower off");
    run_frame(1'b1, 1'b1, "lores lower on");
    load_mem(1'b1);
    run_frame(1'b1, 1'b0, "lores odd cells inverted");
    load_mem(1'b0);
    test_field(1'b1);
    test_field(1'b0);
    finish_run();
  end

endmodule